// File: doc/BRIEF.md
# Interrupt Source State Bank

This block keeps the per-source state of a small bank of interrupt sources and decides when each one should be offered to a presentation controller. Every entry holds a destination server number, an active priority, a remembered priority used for unmasking, and a flag that selects level-sensitive or message-signalled behaviour. It also tracks a two-bit presented/queued pair, a flag for an interrupt that arrived while masked, and a flag for an interrupt that the presentation controller turned away.

Trigger and deassert events, end-of-interrupt events, a bank-wide resend request and configuration writes update the entries. When an entry decides that its interrupt must be offered, it raises an internal request. A round-robin arbiter picks one request, and an output register presents its source number, priority and server until the presentation controller accepts or rejects it. A rejected source is remembered and offered again on the next resend request. An interrupt that arrives while its source is masked is offered again once a usable priority is written.

Top module: `irq_src_bank`

## Requirements
- R1: After reset no delivery is presented and every source has active and saved priority 0xFF (masked), so a trigger to any source that has not been configured presents nothing.
- R2: The state pair is encoded with P (presented) in bit 0 and Q (queued) in bit 1. For a message-signalled source (mode flag 0) in state 00, a trigger (trig_valid with trig_level=1) presents a delivery carrying that source's index, active priority and server.
- R3: A message-signalled trigger sets the pair to ((old << 1) & 3) | 1 and requests delivery only when the result is P=1, Q=0. An end-of-interrupt shifts Q into P and clears Q, and presents the source again only if P is then set.
- R4: A deassert (trig_valid with trig_level=0) on a message-signalled source has no effect.
- R5: For a level-sensitive source (mode flag 1), an assert while P is set is ignored, and otherwise sets the pair to P only and requests delivery. A deassert clears P and Q. An end-of-interrupt keeps the pair and presents the source again if P is set.
- R6: A delivery attempted while the source's active priority is 0xFF presents nothing and sets the source's masked-pending flag. No presented delivery ever carries priority 0xFF.
- R7: A set write (cfg_op=0) stores server, mode, active and saved priority. If that priority is not 0xFF while masked-pending or resend is set, both flags clear and one delivery is requested. The same holds for an unmask write (cfg_op=2), which loads the saved priority into the active priority.
- R8: A mask write (cfg_op=1) copies the active priority into the saved priority and sets the active priority to 0xFF. A later unmask write restores it, and the delivery it causes carries the restored priority.
- R9: A reject (dlv_rej while a delivery is presented) ends that delivery and sets the resend flag of its source. A resend request offers again only the sources whose resend flag is set and clears those flags.
- R10: Events to the same source in one cycle are applied in the order configuration write, then end-of-interrupt, then trigger.
- R11: A presented delivery keeps its source index, priority and server unchanged until dlv_ack or dlv_rej ends it.
- R12: When several sources are requesting, the next one presented is the first requesting index after the last granted index, wrapping around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger or deassert event for one source |
| trig_idx | input | IDX_W | Source index of the trigger event |
| trig_level | input | 1 | 1 for trigger or assert, 0 for deassert |
| eoi_valid | input | 1 | End-of-interrupt event |
| eoi_idx | input | IDX_W | Source index of the end-of-interrupt |
| resend_req | input | 1 | Offer again every source whose resend flag is set |
| cfg_valid | input | 1 | Configuration write |
| cfg_op | input | 2 | 0 set, 1 mask, 2 unmask, 3 no operation |
| cfg_idx | input | IDX_W | Source index of the configuration write |
| cfg_server | input | SRV_W | Server number for a set write |
| cfg_prio | input | PRIO_W | Priority for a set write, 0xFF masks |
| cfg_lsi | input | 1 | Mode for a set write, 1 level-sensitive |
| dlv_valid | output | 1 | A delivery is presented |
| dlv_idx | output | IDX_W | Source index of the presented delivery |
| dlv_prio | output | PRIO_W | Priority of the presented delivery |
| dlv_server | output | SRV_W | Server of the presented delivery |
| dlv_ack | input | 1 | The presentation controller accepted the delivery |
| dlv_rej | input | 1 | The presentation controller rejected the delivery |

## Verification
An event sampled at one rising edge updates the entry's request flag there, and the output register loads at the following edge, so any newly caused delivery is due two edges after its stimulus. A response ends the presented delivery at the edge that samples it, and the next waiting request is loaded at that same edge. The bench drives every stimulus for one cycle starting at a falling edge, lowers it at the next falling edge and samples the outputs one falling edge later. It checks acknowledgements and rejections on the falling edge right after their single sampling edge. The resend flag has no port of its own, so it is checked by issuing a resend request and looking for the delivery it brings two edges later.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

   typedef enum logic [1:0] {
      CFG_SET    = 2'd0,
      CFG_MASK   = 2'd1,
      CFG_UNMASK = 2'd2,
      CFG_NOP    = 2'd3
   } cfg_op_e;

   localparam int PQ_P = 0;
   localparam int PQ_Q = 1;

endpackage

// File: rtl/irq_src_entry.sv
module irq_src_entry
   import irq_src_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int SRV_W  = 4,
   parameter int PRIO_W = 8,
   parameter int ID     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_valid,
   input  logic [IDX_W-1:0]  trig_idx,
   input  logic              trig_level,
   input  logic              eoi_valid,
   input  logic [IDX_W-1:0]  eoi_idx,
   input  logic              resend_req,
   input  logic              cfg_valid,
   input  logic [1:0]        cfg_op,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [SRV_W-1:0]  cfg_server,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic              cfg_lsi,
   input  logic              rej_hit,
   input  logic              grant_hit,
   output logic              req,
   output logic [PRIO_W-1:0] prio,
   output logic [SRV_W-1:0]  server
);

   localparam logic [PRIO_W-1:0] PRIO_MASK = {PRIO_W{1'b1}};
   localparam logic [IDX_W-1:0]  MY_IDX    = IDX_W'(ID);

   logic [SRV_W-1:0]  srv_q,   n_srv;
   logic [PRIO_W-1:0] prio_q,  n_prio;
   logic [PRIO_W-1:0] saved_q, n_saved;
   logic              lsi_q,   n_lsi;
   logic [1:0]        pq_q,    n_pq;
   logic              mp_q,    n_mp;
   logic              rs_q,    n_rs;
   logic              req_q,   n_req;
   logic              want;

   logic trig_hit, eoi_hit, cfg_hit;

   assign trig_hit = trig_valid && (trig_idx == MY_IDX);
   assign eoi_hit  = eoi_valid  && (eoi_idx  == MY_IDX);
   assign cfg_hit  = cfg_valid  && (cfg_idx  == MY_IDX);

   always_comb begin
      n_srv   = srv_q;
      n_prio  = prio_q;
      n_saved = saved_q;
      n_lsi   = lsi_q;
      n_pq    = pq_q;
      n_mp    = mp_q;
      n_rs    = rs_q;
      n_req   = req_q;
      want    = 1'b0;

      if (grant_hit) n_req = 1'b0;
      if (rej_hit)   n_rs  = 1'b1;

      // stage 1: configuration write
      if (cfg_hit) begin
         case (cfg_op_e'(cfg_op))
            CFG_SET: begin
               n_srv   = cfg_server;
               n_prio  = cfg_prio;
               n_saved = cfg_prio;
               n_lsi   = cfg_lsi;
               if ((n_mp || n_rs) && (cfg_prio != PRIO_MASK)) begin
                  n_mp = 1'b0;
                  n_rs = 1'b0;
                  want = 1'b1;
               end
            end
            CFG_MASK: begin
               n_saved = n_prio;
               n_prio  = PRIO_MASK;
            end
            CFG_UNMASK: begin
               n_prio = n_saved;
               if ((n_mp || n_rs) && (n_saved != PRIO_MASK)) begin
                  n_mp = 1'b0;
                  n_rs = 1'b0;
                  want = 1'b1;
               end
            end
            default: ;
         endcase
      end

      // stage 2: end of interrupt
      if (eoi_hit) begin
         if (!n_lsi) n_pq = {1'b0, n_pq[PQ_Q]};
         if (n_pq[PQ_P]) want = 1'b1;
      end

      // stage 3: trigger / deassert
      if (trig_hit) begin
         if (n_lsi) begin
            if (!trig_level) begin
               n_pq = 2'b00;
            end else if (!n_pq[PQ_P]) begin
               n_pq = 2'b01;
               want = 1'b1;
            end
         end else if (trig_level) begin
            n_pq = {n_pq[PQ_P], 1'b1};
            if (n_pq == 2'b01) want = 1'b1;
         end
      end

      // stage 4: replay of rejected sources
      if (resend_req && n_rs) begin
         n_rs = 1'b0;
         want = 1'b1;
      end

      if (want) n_req = 1'b1;

      // a request can never wait on a masked source
      if (n_req && (n_prio == PRIO_MASK)) begin
         n_req = 1'b0;
         n_mp  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         srv_q   <= '0;
         prio_q  <= PRIO_MASK;
         saved_q <= PRIO_MASK;
         lsi_q   <= 1'b0;
         pq_q    <= 2'b00;
         mp_q    <= 1'b0;
         rs_q    <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         srv_q   <= n_srv;
         prio_q  <= n_prio;
         saved_q <= n_saved;
         lsi_q   <= n_lsi;
         pq_q    <= n_pq;
         mp_q    <= n_mp;
         rs_q    <= n_rs;
         req_q   <= n_req;
      end
   end

   assign req    = req_q;
   assign prio   = prio_q;
   assign server = srv_q;

endmodule

// File: rtl/irq_rr_arb.sv
module irq_rr_arb #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             advance,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx
);

   logic [IDX_W-1:0] last_q;

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int i = 0; i < N; i++) begin
         int c;
         c = (int'(last_q) + 1 + i) % N;
         if (!gnt_valid && req[c]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IDX_W'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last_q <= IDX_W'(N - 1);
      else if (advance) last_q <= gnt_idx;
   end

endmodule

// File: rtl/irq_dlv_hold.sv
module irq_dlv_hold #(
   parameter int IDX_W  = 4,
   parameter int SRV_W  = 4,
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gnt_valid,
   input  logic [IDX_W-1:0]  gnt_idx,
   input  logic [PRIO_W-1:0] gnt_prio,
   input  logic [SRV_W-1:0]  gnt_server,
   input  logic              ack,
   input  logic              rej,
   output logic              take,
   output logic              rej_fire,
   output logic              dlv_valid,
   output logic [IDX_W-1:0]  dlv_idx,
   output logic [PRIO_W-1:0] dlv_prio,
   output logic [SRV_W-1:0]  dlv_server
);

   logic resp;

   assign resp     = dlv_valid && (ack || rej);
   assign rej_fire = dlv_valid && rej;
   assign take     = gnt_valid && (!dlv_valid || resp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dlv_valid  <= 1'b0;
         dlv_idx    <= '0;
         dlv_prio   <= '0;
         dlv_server <= '0;
      end else if (take) begin
         dlv_valid  <= 1'b1;
         dlv_idx    <= gnt_idx;
         dlv_prio   <= gnt_prio;
         dlv_server <= gnt_server;
      end else if (resp) begin
         dlv_valid  <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_src_pkg::*;
#(
   parameter  int NUM_SRC = 16,
   parameter  int SRV_W   = 4,
   parameter  int PRIO_W  = 8,
   localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_valid,
   input  logic [IDX_W-1:0]  trig_idx,
   input  logic              trig_level,
   input  logic              eoi_valid,
   input  logic [IDX_W-1:0]  eoi_idx,
   input  logic              resend_req,
   input  logic              cfg_valid,
   input  logic [1:0]        cfg_op,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [SRV_W-1:0]  cfg_server,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic              cfg_lsi,
   output logic              dlv_valid,
   output logic [IDX_W-1:0]  dlv_idx,
   output logic [PRIO_W-1:0] dlv_prio,
   output logic [SRV_W-1:0]  dlv_server,
   input  logic              dlv_ack,
   input  logic              dlv_rej
);

   generate
      if (NUM_SRC < 2)  begin : g_bad_num  $error("NUM_SRC must be at least 2");  end
      if (PRIO_W < 2)   begin : g_bad_prio $error("PRIO_W must be at least 2");   end
      if (SRV_W < 1)    begin : g_bad_srv  $error("SRV_W must be at least 1");    end
   endgenerate

   logic [NUM_SRC-1:0] req_vec;
   logic [PRIO_W-1:0]  prio_a [NUM_SRC];
   logic [SRV_W-1:0]   srv_a  [NUM_SRC];

   logic             gnt_valid;
   logic [IDX_W-1:0] gnt_idx;
   logic             take;
   logic             rej_fire;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
         logic grant_hit, rej_hit;
         assign grant_hit = take     && (gnt_idx == IDX_W'(gi));
         assign rej_hit   = rej_fire && (dlv_idx == IDX_W'(gi));

         irq_src_entry #(
            .IDX_W (IDX_W),
            .SRV_W (SRV_W),
            .PRIO_W(PRIO_W),
            .ID    (gi)
         ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_valid(trig_valid),
            .trig_idx  (trig_idx),
            .trig_level(trig_level),
            .eoi_valid (eoi_valid),
            .eoi_idx   (eoi_idx),
            .resend_req(resend_req),
            .cfg_valid (cfg_valid),
            .cfg_op    (cfg_op),
            .cfg_idx   (cfg_idx),
            .cfg_server(cfg_server),
            .cfg_prio  (cfg_prio),
            .cfg_lsi   (cfg_lsi),
            .rej_hit   (rej_hit),
            .grant_hit (grant_hit),
            .req       (req_vec[gi]),
            .prio      (prio_a[gi]),
            .server    (srv_a[gi])
         );
      end
   endgenerate

   irq_rr_arb #(
      .N    (NUM_SRC),
      .IDX_W(IDX_W)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_vec),
      .advance  (take),
      .gnt_valid(gnt_valid),
      .gnt_idx  (gnt_idx)
   );

   irq_dlv_hold #(
      .IDX_W (IDX_W),
      .SRV_W (SRV_W),
      .PRIO_W(PRIO_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx),
      .gnt_prio  (prio_a[gnt_idx]),
      .gnt_server(srv_a[gnt_idx]),
      .ack       (dlv_ack),
      .rej       (dlv_rej),
      .take      (take),
      .rej_fire  (rej_fire),
      .dlv_valid (dlv_valid),
      .dlv_idx   (dlv_idx),
      .dlv_prio  (dlv_prio),
      .dlv_server(dlv_server)
   );

endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk #(
   parameter int NUM_SRC = 16,
   parameter int SRV_W   = 4,
   parameter int PRIO_W  = 8,
   parameter int IDX_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_valid,
   input logic              eoi_valid,
   input logic              resend_req,
   input logic              cfg_valid,
   input logic              dlv_valid,
   input logic [IDX_W-1:0]  dlv_idx,
   input logic [PRIO_W-1:0] dlv_prio,
   input logic [SRV_W-1:0]  dlv_server,
   input logic              dlv_ack,
   input logic              dlv_rej
);

   localparam logic [PRIO_W-1:0] PRIO_MASK = {PRIO_W{1'b1}};

   logic any_evt;
   assign any_evt = trig_valid || eoi_valid || resend_req || cfg_valid;

   AST_IDLE_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dlv_valid); // R1

   AST_DLV_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dlv_valid) |-> $past(any_evt, 2)); // R2

   AST_NO_MASKED_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> (dlv_prio != PRIO_MASK)); // R6

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !dlv_ack && !dlv_rej) |=>
         (dlv_valid && $stable(dlv_idx) && $stable(dlv_prio) && $stable(dlv_server))); // R11

endmodule

bind irq_src_bank irq_src_bank_chk #(
   .NUM_SRC(NUM_SRC),
   .SRV_W  (SRV_W),
   .PRIO_W (PRIO_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig_valid(trig_valid),
   .eoi_valid (eoi_valid),
   .resend_req(resend_req),
   .cfg_valid (cfg_valid),
   .dlv_valid (dlv_valid),
   .dlv_idx   (dlv_idx),
   .dlv_prio  (dlv_prio),
   .dlv_server(dlv_server),
   .dlv_ack   (dlv_ack),
   .dlv_rej   (dlv_rej)
);

// File: tb/irq_src_bank_test.sv
module irq_src_bank_test;

   localparam int NSRC = 16;
   localparam int IW   = 4;
   localparam int SW   = 4;
   localparam int PW   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_valid = 1'b0;
   logic [IW-1:0] trig_idx = '0;
   logic          trig_level = 1'b0;
   logic          eoi_valid = 1'b0;
   logic [IW-1:0] eoi_idx = '0;
   logic          resend_req = 1'b0;
   logic          cfg_valid = 1'b0;
   logic [1:0]    cfg_op = 2'd3;
   logic [IW-1:0] cfg_idx = '0;
   logic [SW-1:0] cfg_server = '0;
   logic [PW-1:0] cfg_prio = '0;
   logic          cfg_lsi = 1'b0;
   logic          dlv_valid;
   logic [IW-1:0] dlv_idx;
   logic [PW-1:0] dlv_prio;
   logic [SW-1:0] dlv_server;
   logic          dlv_ack = 1'b0;
   logic          dlv_rej = 1'b0;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   irq_src_bank #(.NUM_SRC(NSRC), .SRV_W(SW), .PRIO_W(PW)) uut (
      .clk(clk), .rst_n(rst_n),
      .trig_valid(trig_valid), .trig_idx(trig_idx), .trig_level(trig_level),
      .eoi_valid(eoi_valid), .eoi_idx(eoi_idx), .resend_req(resend_req),
      .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_idx(cfg_idx),
      .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_lsi(cfg_lsi),
      .dlv_valid(dlv_valid), .dlv_idx(dlv_idx), .dlv_prio(dlv_prio),
      .dlv_server(dlv_server), .dlv_ack(dlv_ack), .dlv_rej(dlv_rej)
   );

   // vector: [7:4] source, [3:2] kind (0 assert, 1 deassert, 2 eoi), [0] delivery expected
   localparam logic [7:0] VEC [17] = '{
      8'h11, 8'h10, 8'h10, 8'h14, 8'h19, 8'h18, 8'h18, 8'h11, 8'h18,
      8'h21, 8'h20, 8'h29, 8'h24, 8'h28, 8'h21, 8'h24, 8'h28
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic expect_dlv(input bit ev, input int idx, input int pr, input int sv,
                             input string req);
      chk(dlv_valid == ev, req, "dlv_valid", int'(dlv_valid), int'(ev));
      if (ev && dlv_valid) begin
         chk(int'(dlv_idx) == idx, req, "dlv_idx", int'(dlv_idx), idx);
         chk(int'(dlv_prio) == pr, req, "dlv_prio", int'(dlv_prio), pr);
         chk(int'(dlv_server) == sv, req, "dlv_server", int'(dlv_server), sv);
      end
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic trig(input int idx, input bit lvl);
      trig_valid = 1'b1; trig_idx = IW'(idx); trig_level = lvl;
      @(negedge clk);
      trig_valid = 1'b0;
   endtask

   task automatic eoi(input int idx);
      eoi_valid = 1'b1; eoi_idx = IW'(idx);
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic cfg(input int idx, input int op, input int sv, input int pr, input bit lsi);
      cfg_valid = 1'b1; cfg_idx = IW'(idx); cfg_op = 2'(op);
      cfg_server = SW'(sv); cfg_prio = PW'(pr); cfg_lsi = lsi;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_op = 2'd3;
   endtask

   task automatic resend();
      resend_req = 1'b1;
      @(negedge clk);
      resend_req = 1'b0;
   endtask

   task automatic ack();
      dlv_ack = 1'b1;
      @(negedge clk);
      dlv_ack = 1'b0;
   endtask

   task automatic rej();
      dlv_rej = 1'b1;
      @(negedge clk);
      dlv_rej = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1: idle after reset, unconfigured source is masked
      expect_dlv(1'b0, 0, 0, 0, "R1");
      trig(5, 1'b1);
      settle();
      expect_dlv(1'b0, 0, 0, 0, "R1");
      // R7: latched masked-pending replays on a usable set write
      cfg(5, 0, 2, 7, 1'b0);
      settle();
      expect_dlv(1'b1, 5, 7, 2, "R7");
      ack();
      cfg(5, 0, 2, 6, 1'b0);
      settle();
      expect_dlv(1'b0, 0, 0, 0, "R7");

      // table walk: message source 1 and level source 2
      cfg(1, 0, 3, 5, 1'b0);
      cfg(2, 0, 1, 2, 1'b1);
      settle();
      expect_dlv(1'b0, 0, 0, 0, "R2");
      for (int v = 0; v < 17; v++) begin
         int src;
         int kind;
         bit ev;
         string tag;
         src  = int'(VEC[v][7:4]);
         kind = int'(VEC[v][3:2]);
         ev   = VEC[v][0];
         if (src == 1) tag = (kind == 1) ? "R4" : ((v == 0) ? "R2" : "R3");
         else          tag = "R5";
         if (kind == 0)      trig(src, 1'b1);
         else if (kind == 1) trig(src, 1'b0);
         else                eoi(src);
         settle();
         expect_dlv(ev, src, (src == 1) ? 5 : 2, (src == 1) ? 3 : 1, tag);
         if (dlv_valid) ack();
      end

      // R6 / R8: mask, trigger while masked, unmask restores priority
      cfg(6, 0, 1, 9, 1'b0);
      cfg(6, 1, 0, 0, 1'b0);
      trig(6, 1'b1);
      settle();
      expect_dlv(1'b0, 0, 0, 0, "R6");
      cfg(6, 2, 0, 0, 1'b0);
      settle();
      expect_dlv(1'b1, 6, 9, 1, "R8");
      ack();
      cfg(6, 2, 0, 0, 1'b0);
      settle();
      expect_dlv(1'b0, 0, 0, 0, "R7");

      // R9: reject then resend only the flagged source
      cfg(7, 0, 0, 4, 1'b0);
      cfg(8, 0, 0, 4, 1'b0);
      trig(7, 1'b1);
      settle();
      expect_dlv(1'b1, 7, 4, 0, "R9");
      rej();
      expect_dlv(1'b0, 0, 0, 0, "R9");
      resend();
      settle();
      expect_dlv(1'b1, 7, 4, 0, "R9");
      ack();
      expect_dlv(1'b0, 0, 0, 0, "R9");
      resend();
      settle();
      expect_dlv(1'b0, 0, 0, 0, "R9");

      // R10: eoi applied before deassert in the same cycle
      trig(2, 1'b1);
      settle();
      expect_dlv(1'b1, 2, 2, 1, "R10");
      ack();
      eoi_valid = 1'b1; eoi_idx = 4'd2;
      trig_valid = 1'b1; trig_idx = 4'd2; trig_level = 1'b0;
      @(negedge clk);
      eoi_valid = 1'b0; trig_valid = 1'b0;
      settle();
      expect_dlv(1'b1, 2, 2, 1, "R10");
      ack();
      eoi(2);
      settle();
      expect_dlv(1'b0, 0, 0, 0, "R10");

      // R11 / R12: hold and round-robin order
      cfg(11, 0, 0, 1, 1'b0);
      cfg(12, 0, 0, 2, 1'b0);
      cfg(13, 0, 0, 3, 1'b0);
      cfg(4, 0, 0, 6, 1'b0);
      trig(11, 1'b1);
      trig(12, 1'b1);
      trig(13, 1'b1);
      expect_dlv(1'b1, 11, 1, 0, "R11");
      repeat (3) settle();
      expect_dlv(1'b1, 11, 1, 0, "R11");
      ack();
      expect_dlv(1'b1, 12, 2, 0, "R12");
      trig(4, 1'b1);
      expect_dlv(1'b1, 12, 2, 0, "R11");
      ack();
      expect_dlv(1'b1, 13, 3, 0, "R12");
      ack();
      expect_dlv(1'b1, 4, 6, 0, "R12");
      ack();
      expect_dlv(1'b0, 0, 0, 0, "R12");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule